// File: doc/BRIEF.md
# Lock-Gated Reset Sequencer

This block orders the removal of reset across three groups: the external converter devices, the clock-management units that lock onto the clock those converters return, and the logic clocked from those units. The host holds a reset command for as long as it wants the system quiet. While that command is high, all three groups are held in reset. When the host clears it, the converters are let go first. The clock managers are released only once the returning converter clock is seen toggling. The downstream logic is released only after every clock manager reports a stable lock.

Converter clock presence is judged by counting synchronized rising edges inside a fixed window of control-clock cycles. Lock inputs pass through two-flop synchronizers. Their AND must then hold for a run of consecutive cycles before it counts as a lock. If lock is lost after start-up, only the logic goes back into reset. If the converter clock is lost, the clock managers and the logic go back into reset. All outputs are registered in the control clock domain.

Top module: `lock_gated_rst_seq`

## Requirements
- R1: While `rst` is high, `conv_rst_o`, `mgr_rst_o` and `logic_rst_o` are 1 and `ready_o` is 0.
- R2: When `host_rst_i` is 1 at a clock edge, all three reset outputs are 1 and `ready_o` is 0 after that edge. They stay so for as long as `host_rst_i` stays 1, whatever the converter clock and the lock inputs do.
- R3: On the first edge after `host_rst_i` returns to 0, `conv_rst_o` drops to 0 while `mgr_rst_o` and `logic_rst_o` stay 1.
- R4: `mgr_rst_o` is released only while the converter clock counts as present. Present means at least MIN_EDGES (8) synchronized rising edges of `conv_clk_i` within one WINDOW (64) cycle window of `clk`. A clock at 1/10 of `clk` or slower, or no clock at all, keeps `mgr_rst_o` at 1.
- R5: `logic_rst_o` is released only after the synchronized AND of all `mgr_lock_i` bits has been 1 for LOCK_HOLD (16) consecutive cycles. A lock pulse shorter than that releases nothing.
- R6: `ready_o` is 1 exactly when all three reset outputs are 0.
- R7: If any lock bit falls while the logic is running, `logic_rst_o` returns to 1 and `ready_o` to 0 within 5 cycles. `mgr_rst_o` and `conv_rst_o` stay 0. The logic is released again after a fresh qualified lock.
- R8: If the converter clock stops after the clock managers were released, `mgr_rst_o` and `logic_rst_o` return to 1 while `conv_rst_o` stays 0. They are released again in order once the clock returns.
- R9: `logic_rst_o` is never 0 while `mgr_rst_o` is 1, and `mgr_rst_o` is never 0 while `conv_rst_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| host_rst_i | input | 1 | Host reset command, level, held until the host clears it |
| conv_clk_i | input | 1 | Clock returned by the converters, sampled as data |
| mgr_lock_i | input | N_LOCK | Lock indication from each clock-management unit |
| conv_rst_o | output | 1 | Reset to the converter devices |
| mgr_rst_o | output | 1 | Reset to the clock-management units |
| logic_rst_o | output | 1 | Reset to logic clocked from the clock managers |
| ready_o | output | 1 | All resets released |

## Verification
The bench sweeps converter clock rates on both sides of the edge-count threshold. A detector that counted falling and rising edges, or compared against the wrong limit, would free the clock managers on a slow clock. A lock pulse shorter than the qualification run is applied. A design that gated on raw lock would release the logic early. Lock is then dropped during running, and later the converter clock is stopped. A sequencer that returned to the full-hold state, or never left running, would show the wrong reset pattern. Host reset is also raised mid-run and held with clock and lock active, which catches a design that lets the command lapse or releases groups together.

// File: rtl/lgrs_pkg.sv
package lgrs_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_WCLK  = 2'd1,
    ST_WLOCK = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/clk_presence_det.sv
// Counts synchronized rising edges of a foreign clock per fixed window.
module clk_presence_det #(
  parameter int WINDOW    = 64,
  parameter int MIN_EDGES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sense_i,
  output logic present_o
);
  localparam int WW = $clog2(WINDOW);
  localparam int CW = $clog2(MIN_EDGES + 1);

  logic          s1, s2, s3;
  logic          rise;
  logic [WW-1:0] win_cnt;
  logic [CW-1:0] edge_cnt;

  assign rise = s2 & ~s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sense_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt   <= '0;
      edge_cnt  <= '0;
      present_o <= 1'b0;
    end else if (win_cnt == WW'(WINDOW - 1)) begin
      win_cnt   <= '0;
      edge_cnt  <= '0;
      present_o <= (edge_cnt == CW'(MIN_EDGES));
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (rise && edge_cnt != CW'(MIN_EDGES))
        edge_cnt <= edge_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lock_qualifier.sv
// Synchronizes lock bits and requires a run of consecutive good cycles.
module lock_qualifier #(
  parameter int N_LOCK    = 2,
  parameter int LOCK_HOLD = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic [N_LOCK-1:0] lock_i,
  output logic              stable_o
);
  localparam int HW = $clog2(LOCK_HOLD + 1);

  logic [N_LOCK-1:0] meta, sync;
  logic [HW-1:0]     run_cnt;

  for (genvar g = 0; g < N_LOCK; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[g] <= 1'b0;
        sync[g] <= 1'b0;
      end else begin
        meta[g] <= lock_i[g];
        sync[g] <= meta[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i || !(&sync))
      run_cnt <= '0;
    else if (run_cnt != HW'(LOCK_HOLD))
      run_cnt <= run_cnt + 1'b1;
  end

  assign stable_o = (run_cnt == HW'(LOCK_HOLD));
endmodule

// File: rtl/seq_fsm.sv
// Stage machine: hold all, wait for clock, wait for lock, run.
module seq_fsm
  import lgrs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic host_rst_i,
  input  logic clk_ok_i,
  input  logic lock_ok_i,
  output logic conv_rst_o,
  output logic mgr_rst_o,
  output logic logic_rst_o,
  output logic ready_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HOLD:  st_d = ST_WCLK;
      ST_WCLK:  if (clk_ok_i) st_d = ST_WLOCK;
      ST_WLOCK: if (!clk_ok_i) st_d = ST_WCLK;
                else if (lock_ok_i) st_d = ST_RUN;
      ST_RUN:   if (!clk_ok_i) st_d = ST_WCLK;
                else if (!lock_ok_i) st_d = ST_WLOCK;
      default:  st_d = ST_HOLD;
    endcase
    if (host_rst_i) st_d = ST_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_HOLD;
      conv_rst_o  <= 1'b1;
      mgr_rst_o   <= 1'b1;
      logic_rst_o <= 1'b1;
      ready_o     <= 1'b0;
    end else begin
      st_q        <= st_d;
      conv_rst_o  <= (st_d == ST_HOLD);
      mgr_rst_o   <= (st_d == ST_HOLD) || (st_d == ST_WCLK);
      logic_rst_o <= (st_d != ST_RUN);
      ready_o     <= (st_d == ST_RUN);
    end
  end
endmodule

// File: rtl/lock_gated_rst_seq.sv
module lock_gated_rst_seq #(
  parameter int N_LOCK    = 2,
  parameter int WINDOW    = 64,
  parameter int MIN_EDGES = 8,
  parameter int LOCK_HOLD = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rst_i,
  input  logic              conv_clk_i,
  input  logic [N_LOCK-1:0] mgr_lock_i,
  output logic              conv_rst_o,
  output logic              mgr_rst_o,
  output logic              logic_rst_o,
  output logic              ready_o
);
  logic clk_ok, lock_ok;

  clk_presence_det #(.WINDOW(WINDOW), .MIN_EDGES(MIN_EDGES)) i_det (
    .clk       (clk),
    .rst       (rst),
    .sense_i   (conv_clk_i),
    .present_o (clk_ok)
  );

  lock_qualifier #(.N_LOCK(N_LOCK), .LOCK_HOLD(LOCK_HOLD)) i_lock (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (mgr_rst_o),
    .lock_i   (mgr_lock_i),
    .stable_o (lock_ok)
  );

  seq_fsm i_fsm (
    .clk         (clk),
    .rst         (rst),
    .host_rst_i  (host_rst_i),
    .clk_ok_i    (clk_ok),
    .lock_ok_i   (lock_ok),
    .conv_rst_o  (conv_rst_o),
    .mgr_rst_o   (mgr_rst_o),
    .logic_rst_o (logic_rst_o),
    .ready_o     (ready_o)
  );
endmodule

// File: rtl/lock_gated_rst_seq_chk.sv
module lock_gated_rst_seq_chk #(
  parameter int N_LOCK = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              host_rst_i,
  input logic [N_LOCK-1:0] mgr_lock_i,
  input logic              conv_rst_o,
  input logic              mgr_rst_o,
  input logic              logic_rst_o,
  input logic              ready_o
);
  a_r2_host_holds_all: assert property (@(posedge clk) disable iff (rst)
    host_rst_i |=> (conv_rst_o && mgr_rst_o && logic_rst_o && !ready_o));

  a_r3_conv_first: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_rst_o) |-> (mgr_rst_o && logic_rst_o));

  a_r5_lock_before_logic: assert property (@(posedge clk) disable iff (rst)
    $fell(logic_rst_o) |-> (&$past(mgr_lock_i)));

  a_r6_ready_all_free: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (!conv_rst_o && !mgr_rst_o && !logic_rst_o));

  a_r8_conv_stays_free: assert property (@(posedge clk) disable iff (rst)
    ($rose(mgr_rst_o) && !$past(host_rst_i)) |-> !conv_rst_o);

  a_r9_order_logic: assert property (@(posedge clk) disable iff (rst)
    !logic_rst_o |-> !mgr_rst_o);

  a_r9_order_mgr: assert property (@(posedge clk) disable iff (rst)
    !mgr_rst_o |-> !conv_rst_o);
endmodule

bind lock_gated_rst_seq lock_gated_rst_seq_chk #(.N_LOCK(N_LOCK)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .host_rst_i  (host_rst_i),
  .mgr_lock_i  (mgr_lock_i),
  .conv_rst_o  (conv_rst_o),
  .mgr_rst_o   (mgr_rst_o),
  .logic_rst_o (logic_rst_o),
  .ready_o     (ready_o)
);

// File: tb/test_lock_gated_rst_seq.sv
`timescale 1ns/1ps
module test_lock_gated_rst_seq;
  localparam int NL = 2;
  localparam int NV = 6;
  localparam int HALF [NV] = '{1, 2, 3, 5, 8, 0};
  localparam bit EXPP [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_rst = 1'b1;
  logic          conv_clk = 1'b0;
  logic [NL-1:0] lock = '0;
  logic          conv_rst, mgr_rst, logic_rst, ready;
  int            half = 0;
  int            checks = 0;
  int            errors = 0;
  int            order_viol = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  lock_gated_rst_seq #(.N_LOCK(NL)) i_lock_gated_rst_seq (
    .clk(clk), .rst(rst), .host_rst_i(host_rst), .conv_clk_i(conv_clk),
    .mgr_lock_i(lock), .conv_rst_o(conv_rst), .mgr_rst_o(mgr_rst),
    .logic_rst_o(logic_rst), .ready_o(ready)
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (half == 0) ph = 0;
      else begin
        ph++;
        if (ph >= half) begin ph = 0; conv_clk = ~conv_clk; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!rst && ((!logic_rst && mgr_rst) || (!mgr_rst && conv_rst))) order_viol++;
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    wait_cyc(6);
    // R1 reset state
    chk(conv_rst && mgr_rst && logic_rst && !ready, "R1 reset state",
        {conv_rst, mgr_rst, logic_rst, ready}, 4'b1110);
    rst = 1'b0;
    wait_cyc(3);

    // Table of converter clock rates: R3 ordering at release, R4 presence
    for (int v = 0; v < NV; v++) begin
      host_rst = 1'b1;
      lock = '0;
      half = HALF[v];
      wait_cyc(5);
      host_rst = 1'b0;
      wait_cyc(1);
      chk(!conv_rst && mgr_rst && logic_rst, "R3 converter released first",
          {conv_rst, mgr_rst, logic_rst}, 3'b011);
      wait_cyc(200);
      chk(mgr_rst == !EXPP[v], "R4 clock presence gates manager reset", mgr_rst, !EXPP[v]);
      chk(logic_rst, "R5 no lock keeps logic reset", logic_rst, 1);
    end

    // R5 short lock pulse, then qualified lock
    half = 2;
    wait_cyc(200);
    chk(!mgr_rst, "R4 fast clock frees managers", mgr_rst, 0);
    lock = '1;
    wait_cyc(10);
    lock = '0;
    wait_cyc(30);
    chk(logic_rst && !ready, "R5 short lock pulse ignored", logic_rst, 1);
    lock = 2'b01;
    wait_cyc(40);
    chk(logic_rst, "R5 partial lock ignored", logic_rst, 1);
    lock = '1;
    wait_cyc(15);
    chk(!ready && logic_rst, "R5 release not before hold run", ready, 0);
    wait_cyc(10);
    chk(ready && !logic_rst, "R6 ready after qualified lock", ready, 1);

    // R7 lock loss in run
    lock = 2'b10;
    wait_cyc(5);
    chk(logic_rst && !ready, "R7 lock loss resets logic", logic_rst, 1);
    chk(!mgr_rst && !conv_rst, "R7 managers stay released", {conv_rst, mgr_rst}, 0);
    lock = '1;
    wait_cyc(30);
    chk(ready, "R7 recovery after relock", ready, 1);

    // R8 converter clock loss
    half = 0;
    wait_cyc(200);
    chk(mgr_rst && logic_rst && !ready, "R8 clock loss resets managers",
        {mgr_rst, logic_rst}, 2'b11);
    chk(!conv_rst, "R8 converter stays released", conv_rst, 0);
    half = 2;
    wait_cyc(250);
    chk(ready && !mgr_rst, "R8 recovery after clock returns", ready, 1);

    // R2 host reset mid-run and held
    host_rst = 1'b1;
    wait_cyc(1);
    chk(conv_rst && mgr_rst && logic_rst && !ready, "R2 host reset asserts all",
        {conv_rst, mgr_rst, logic_rst, ready}, 4'b1110);
    wait_cyc(300);
    chk(conv_rst && mgr_rst && logic_rst && !ready, "R2 held while host command high",
        {conv_rst, mgr_rst, logic_rst, ready}, 4'b1110);
    host_rst = 1'b0;
    wait_cyc(1);
    chk(!conv_rst && mgr_rst && logic_rst, "R3 staged release after host clear",
        {conv_rst, mgr_rst, logic_rst}, 3'b011);
    wait_cyc(250);
    chk(ready, "R6 ready after full sequence", ready, 1);

    chk(order_viol == 0, "R9 release order kept", order_viol, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule